// File: doc/BRIEF.md
# Parallel Control Latch for a Step Attenuator

This block owns the 7-bit attenuation word that drives the switch core of a digital step attenuator while the attenuator is controlled from parallel pins. Bit i of the word switches in 0.25 dB × 2^i. All zeros gives the reference insertion-loss state and all ones gives the maximum of 31.75 dB. A mode-select input picks parallel control (low) or the serial addressable path (high). The serial shift logic lives elsewhere: while serial is selected, this block only keeps its word.

In parallel mode the latch-enable input sets the behaviour. When it is held high, the word is transparent and follows the control pins (direct mode). When it is low, the word holds while the pins change, and a high-then-low pulse transfers the pins into the word (latched mode). All asynchronous inputs pass through a synchroniser before anything else uses them.

After the power-up strobe the word sits at maximum attenuation. The synchronised inputs then decide what happens next. In direct mode a counter holds the maximum for a programmable number of cycles, about 400 µs of system clock, and then the preset pins take effect. In latched or serial power-up, the maximum remains until a first complete latch pulse arrives in parallel mode.

Top module: `stepatt_par_ctrl`

## Requirements
- R1: Output bit i carries the control pin i unchanged, weighted 0.25 dB × 2^i: 7'h00 is the reference state, 7'h01 is 0.25 dB, 7'h40 is 16 dB and 7'h7F is 31.75 dB.
- R2: While mode select is high, the control pins and latch enable have no effect and the word keeps its value. A low mode select hands control back to the parallel pins.
- R3: In parallel mode with latch enable high (after power-up), the word follows the control pins.
- R4: In parallel mode with latch enable low, the word holds. After a high-then-low latch pulse, the word equals the pins present at the falling edge.
- R5: During reset the word is 7'h7F. After a power-up in serial mode or in latched mode, it stays 7'h7F until the first complete latch pulse seen in parallel mode.
- R6: After a power-up in direct mode, the word stays 7'h7F for HOLD_CYCLES cycles after the mode decision and then takes the preset pins. It is 7'h7F after 3+HOLD_CYCLES rising edges from reset release and takes the preset after 4+HOLD_CYCLES.
- R7: A direct-mode power-up with the control pins low (pulled down when left undriven) ends in the minimum state 7'h00.
- R8: Every input crosses SYNC_STAGES flops before use. A pin change (or a latch-enable fall) reaches the output after SYNC_STAGES+1 rising edges, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up strobe |
| ser_sel_i | input | 1 | Mode select: 1 = serial path owns the word, 0 = parallel pins |
| le_i | input | 1 | Latch enable: held high = direct, pulsed = latched |
| ctl_i | input | WORD_W | Parallel attenuation control pins, LSB = 0.25 dB |
| atten_o | output | WORD_W | Attenuation word to the switch core |

## Verification
A control-pin change made in parallel transparent operation is due at the output after the third rising edge: two synchroniser flops and the word register. The bench therefore checks that the old value is still present after two edges and that the new value appears after three. A latch-enable fall has the same three-edge latency. The direct power-up preset is due after exactly 4+HOLD_CYCLES edges from reset release, and the bench confirms the maximum is still present one edge earlier. Every sample is taken on the falling clock edge after the counted rising edges. Inputs are driven on that same falling edge.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;

    // Power-up sequencing phases
    typedef enum logic [1:0] {
        PUP_SETTLE = 2'd0,  // synchroniser filling, word at maximum
        PUP_HOLD   = 2'd1,  // direct mode: timed hold at maximum
        PUP_WAIT   = 2'd2,  // latched/serial: maximum until first pulse
        PUP_RUN    = 2'd3   // normal operation
    } pup_state_e;

endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/stepatt_edge.sv
module stepatt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_d;
    logic lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

endmodule

// File: rtl/stepatt_pup_seq.sv
module stepatt_pup_seq
    import stepatt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_s_i,
    input  logic       le_s_i,
    input  logic       le_rise_i,
    input  logic       le_fall_i,
    output pup_state_e state_o,
    output logic       first_latch_o
);

    localparam int CNT_MAX = (HOLD_CYCLES > SYNC_STAGES) ? HOLD_CYCLES : SYNC_STAGES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pup_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d         = seq_q;
        first_latch_o = 1'b0;
        case (seq_q.state)
            PUP_SETTLE: begin
                // decide once the synchroniser holds real pin values
                if (seq_q.cnt == CNT_W'(SYNC_STAGES)) begin
                    seq_d.cnt   = '0;
                    seq_d.state = (!ser_s_i && le_s_i) ? PUP_HOLD : PUP_WAIT;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PUP_HOLD: begin
                if (seq_q.cnt == CNT_W'(HOLD_CYCLES - 1)) begin
                    seq_d.cnt   = '0;
                    seq_d.state = PUP_RUN;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PUP_WAIT: begin
                if (!ser_s_i) begin
                    if (le_rise_i) begin
                        seq_d.armed = 1'b1;
                    end
                    if (le_fall_i && seq_q.armed) begin
                        first_latch_o = 1'b1;
                        seq_d.armed   = 1'b0;
                        seq_d.state   = PUP_RUN;
                    end
                end
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: PUP_SETTLE, cnt: '0, armed: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.state;

endmodule

// File: rtl/stepatt_par_ctrl.sv
module stepatt_par_ctrl
    import stepatt_pkg::*;
#(
    parameter int WORD_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_i,
    input  logic              le_i,
    input  logic [WORD_W-1:0] ctl_i,
    output logic [WORD_W-1:0] atten_o
);

    localparam int                BUS_W     = WORD_W + 2;
    localparam logic [WORD_W-1:0] MAX_ATTEN = '1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } word_t;

    logic [BUS_W-1:0]  bus_s;
    logic              ser_s;
    logic              le_s;
    logic [WORD_W-1:0] ctl_s;
    logic              le_rise;
    logic              le_fall;
    logic              first_latch;
    pup_state_e        pup_state;
    word_t             word_d;
    word_t             word_q;

    stepatt_sync #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_sel_i, le_i, ctl_i}),
        .sync_o  (bus_s)
    );

    assign {ser_s, le_s, ctl_s} = bus_s;

    stepatt_edge u_le_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (le_s),
        .rise_o (le_rise),
        .fall_o (le_fall)
    );

    stepatt_pup_seq #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_s_i       (ser_s),
        .le_s_i        (le_s),
        .le_rise_i     (le_rise),
        .le_fall_i     (le_fall),
        .state_o       (pup_state),
        .first_latch_o (first_latch)
    );

    always_comb begin
        word_d = word_q;
        case (pup_state)
            PUP_SETTLE, PUP_HOLD: begin
                word_d.word = MAX_ATTEN;
            end
            PUP_WAIT: begin
                if (first_latch) begin
                    word_d.word = ctl_s;
                end
            end
            default: begin
                // transparent while enable high; low freezes the last value
                if (!ser_s && le_s) begin
                    word_d.word = ctl_s;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '{word: MAX_ATTEN};
        end else begin
            word_q <= word_d;
        end
    end

    assign atten_o = word_q.word;

endmodule

// File: rtl/stepatt_par_ctrl_chk.sv
module stepatt_par_ctrl_chk
    import stepatt_pkg::*;
#(
    parameter int WORD_W      = 7,
    parameter int HOLD_CYCLES = 40000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] atten_o,
    input logic              ser_s,
    input logic              le_s,
    input logic [WORD_W-1:0] ctl_s,
    input pup_state_e        state,
    input logic              first_latch
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 2);

    logic [CNT_W-1:0] hold_cnt;
    logic             was_hold;
    logic             was_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            was_hold <= 1'b0;
            was_run  <= 1'b0;
        end else begin
            hold_cnt <= (state == PUP_HOLD) ? hold_cnt + 1'b1 : '0;
            was_hold <= (state == PUP_HOLD);
            was_run  <= (state == PUP_RUN);
        end
    end

    a_r5_max_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PUP_RUN) |-> (atten_o == '1));

    a_r5_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> (state == PUP_RUN));

    a_r2_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PUP_RUN && ser_s) |=> $stable(atten_o));

    a_r4_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PUP_RUN && !ser_s && !le_s) |=> $stable(atten_o));

    a_r3_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PUP_RUN && !ser_s && le_s) |=> (atten_o == $past(ctl_s)));

    a_r4_first_latch: assert property (@(posedge clk) disable iff (!rst_n)
        first_latch |=> (atten_o == $past(ctl_s) && state == PUP_RUN));

    a_r6_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PUP_HOLD) |-> (hold_cnt < CNT_W'(HOLD_CYCLES)));

    a_r6_hold_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PUP_RUN && was_hold) |-> (hold_cnt == CNT_W'(HOLD_CYCLES)));

endmodule

bind stepatt_par_ctrl stepatt_par_ctrl_chk #(
    .WORD_W      (WORD_W),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .atten_o     (atten_o),
    .ser_s       (ser_s),
    .le_s        (le_s),
    .ctl_s       (ctl_s),
    .state       (pup_state),
    .first_latch (first_latch)
);

// File: tb/stepatt_par_ctrl_test.sv
module stepatt_par_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 7;
    localparam int SYNC       = 2;
    localparam int HOLD       = 20;
    localparam int LAT        = SYNC + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ser_sel = 1'b0;
    logic              le = 1'b0;
    logic [WORD_W-1:0] ctl = '0;
    logic [WORD_W-1:0] atten;

    int n_checks = 0;
    int n_fails  = 0;

    stepatt_par_ctrl #(
        .WORD_W      (WORD_W),
        .SYNC_STAGES (SYNC),
        .HOLD_CYCLES (HOLD)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_sel_i (ser_sel),
        .le_i      (le),
        .ctl_i     (ctl),
        .atten_o   (atten)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [WORD_W-1:0] exp);
        n_checks++;
        if (atten !== exp) begin
            n_fails++;
            $display("FAIL %s: atten actual=%h expected=%h", req, atten, exp);
        end
    endtask

    // Reset with given pins; released on a falling edge
    task automatic power_up(input logic s, input logic l, input logic [WORD_W-1:0] d);
        @(negedge clk);
        rst_n   = 1'b0;
        ser_sel = s;
        le      = l;
        ctl     = d;
        edges(3);
        check("R5 reset value", 7'h7F);
        rst_n = 1'b1;
    endtask

    task automatic pulse_le(input int high_cycles);
        le = 1'b1;
        edges(high_cycles);
        le = 1'b0;
    endtask

    task automatic t_direct;
        power_up(1'b0, 1'b1, 7'h49);
        edges(3 + HOLD);
        check("R6 still maximum at end of hold", 7'h7F);
        edges(1);
        check("R6 preset applied", 7'h49);
        ctl = 7'h12;
        edges(LAT - 1);
        check("R8 not yet propagated", 7'h49);
        edges(1);
        check("R3 direct follow", 7'h12);
        foreach (pat[i]) begin
            ctl = pat[i];
            edges(LAT);
            check("R1 bit weight pattern", pat[i]);
        end
    endtask

    logic [WORD_W-1:0] pat [4] = '{7'h7F, 7'h01, 7'h40, 7'h00};

    task automatic t_direct_float;
        power_up(1'b0, 1'b1, 7'h00);
        edges(3 + HOLD);
        check("R6 hold before floating preset", 7'h7F);
        edges(1);
        check("R7 floating preset gives minimum", 7'h00);
    endtask

    task automatic t_latched;
        power_up(1'b0, 1'b0, 7'h05);
        edges(8);
        check("R5 latched power-up maximum", 7'h7F);
        ctl = 7'h2C;
        edges(6);
        check("R5 pins ignored before first pulse", 7'h7F);
        le = 1'b1;
        edges(4);
        check("R5 enable high alone does not latch", 7'h7F);
        le = 1'b0;
        edges(LAT - 1);
        check("R8 latch not yet visible", 7'h7F);
        edges(1);
        check("R4 first latch pulse", 7'h2C);
        ctl = 7'h63;
        edges(6);
        check("R4 hold while enable low", 7'h2C);
        pulse_le(2);
        edges(LAT);
        check("R4 second latch pulse", 7'h63);
    endtask

    task automatic t_serial;
        power_up(1'b1, 1'b0, 7'h33);
        edges(6);
        check("R5 serial power-up maximum", 7'h7F);
        pulse_le(3);
        edges(LAT + 2);
        check("R2 pulse ignored in serial mode", 7'h7F);
        ser_sel = 1'b0;
        ctl     = 7'h2A;
        edges(LAT);
        pulse_le(3);
        edges(LAT);
        check("R2 parallel control restored", 7'h2A);
        ser_sel = 1'b1;
        edges(LAT);
        le  = 1'b1;
        ctl = 7'h15;
        edges(6);
        check("R2 pins ignored in serial mode", 7'h2A);
        le = 1'b0;
        edges(2);
    endtask

    initial begin
        t_direct();
        t_direct_float();
        t_latched();
        t_serial();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule